// File: doc/BRIEF.md
# BCD Seven-Segment LCD Segment Driver

This block turns a 4-bit binary-coded-decimal digit into the seven segment lines of a liquid-crystal digit, and it can store the code. A latch-enable control makes the code store transparent, so it follows the data input while the control is high and keeps the last code while it is low. A blanking control switches every segment off. Codes above nine also give a dark digit.

Liquid crystals need AC drive. A phase control therefore flips every segment line. When the same square wave drives the phase control and the display backplane, each lit segment sees a voltage that alternates in sign, and each dark segment sees none. The phase can come from the `phase_i` pin. With a build parameter it comes instead from an internal clock divider, and the block then also drives the backplane line.

All inputs are sampled on the rising clock edge, and the segment and backplane outputs are registered. Reset is asynchronous and active low. Its release passes through a two-stage synchronizer.

Top module: `lcd7_driver`

## Requirements
- R1: The segment word is bit 0 = a through bit 6 = g, with 1 meaning on when the phase is low. The data input is weighted 8-4-2-1 with bit 3 the most significant. The digits give these words: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R2: While `latch_en_i` is high, the stored code takes the value of `bcd_i` at every rising edge. The output register shows that code's pattern after the same edge, one cycle after the input was applied.
- R3: While `latch_en_i` is low, changes on `bcd_i` have no effect. The output keeps showing the code last stored while the enable was high.
- R4: Codes 10 to 15 produce the all-off word (0x00 when the phase is low).
- R5: While `blank_i` is high, the word is all-off whatever the code. The stored code is not changed, and it shows again once blanking ends.
- R6: When the sampled phase is high, every segment bit is the inverse of its phase-low value. This includes blank words, so a blank digit then reads 0x7F.
- R7: While the reset is active, the stored code is cleared to 0 and the outputs show the blank word for the current phase. After release, with the enable low, the digit 0 pattern appears.
- R8: `backplane_o` equals the phase that was applied to the segment word in the same output cycle.
- R9: With `USE_PHASE_GEN`=1, the phase is an internal square wave with a period of `PH_DIV` cycles, high for half of each period, and `phase_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bcd_i | input | 4 | BCD digit code, bit 3 the most significant |
| latch_en_i | input | 1 | High: code store follows `bcd_i`; low: hold |
| blank_i | input | 1 | High: all segments off |
| phase_i | input | 1 | Phase control, inverts the segment word when high (ignored with the internal generator) |
| seg_o | output | 7 | Segment lines, bit 0 = a ... bit 6 = g |
| backplane_o | output | 1 | Phase applied to the current segment word, for the display backplane |

## Verification
The main instance is built with `USE_PHASE_GEN`=0. It takes the phase from the pin, so random and directed phase values can be combined freely with every code, the enable and blanking. This includes phase-high blank words and all sixteen codes in both phases. A second instance is built with `USE_PHASE_GEN`=1 and `PH_DIV`=6. Its short half-period of three cycles lets the bench measure many backplane run lengths. The bench also checks that the segment word inverts in the same cycle as the backplane, while the pin phase is driven at random.

// File: rtl/lcd7_pkg.sv
package lcd7_pkg;
  localparam int CODE_W   = 4;
  localparam int SEG_W    = 7;
  localparam int N_DIGITS = 10;

  typedef logic [N_DIGITS-1:0] digit_mask_t;

  // For each segment (index 0 = a .. 6 = g), bit i set when digit i lights it.
  localparam digit_mask_t SEG_LIT [SEG_W] = '{
    10'h3ED,  // a
    10'h39F,  // b
    10'h3FB,  // c
    10'h36D,  // d
    10'h145,  // e
    10'h371,  // f
    10'h37C   // g
  };
endpackage

// File: rtl/lcd7_rst_sync.sv
module lcd7_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/lcd7_code_store.sv
module lcd7_code_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         load_en,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_q,
  output logic [W-1:0] code_eff
);
  logic [W-1:0] code_nxt;

  always_comb begin
    code_nxt = code_q;
    if (load_en) code_nxt = code_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) code_q <= '0;
    else         code_q <= code_nxt;
  end

  // Transparent view: what the store holds after this edge.
  assign code_eff = load_en ? code_in : code_q;

  assert_load_follows_R2: assert property (@(posedge clk) disable iff (!srst_n)
    load_en |=> (code_q == $past(code_in)));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !load_en |=> $stable(code_q));
endmodule

// File: rtl/lcd7_seg_decode.sv
module lcd7_seg_decode
  import lcd7_pkg::*;
#(
  parameter int W = CODE_W,
  parameter int S = SEG_W
) (
  input  logic [W-1:0] code,
  input  logic         dark,
  input  logic         phase,
  output logic [S-1:0] seg
);
  localparam int SPAN = 2 ** W;

  logic [S-1:0] lit;

  for (genvar s = 0; s < S; s++) begin : g_seg
    // Codes beyond nine index the zero-extended upper part: always off.
    localparam logic [SPAN-1:0] MASK = SPAN'(SEG_LIT[s]);
    assign lit[s] = MASK[code] & ~dark;
  end

  assign seg = lit ^ {S{phase}};
endmodule

// File: rtl/lcd7_phase_gen.sv
module lcd7_phase_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic srst_n,
  output logic phase
);
  localparam int HALF = (DIV < 2) ? 1 : DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          ph_q, ph_nxt;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    ph_nxt  = ph_q;
    if (wrap) begin
      cnt_nxt = '0;
      ph_nxt  = ~ph_q;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      ph_q  <= ph_nxt;
    end
  end

  assign phase = ph_q;

  assert_toggle_at_wrap_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (ph_q != $past(ph_q)) |-> ($past(cnt_q) == LAST));

  assert_count_in_range_R9: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/lcd7_driver.sv
module lcd7_driver
  import lcd7_pkg::*;
#(
  parameter bit USE_PHASE_GEN = 1'b0,
  parameter int PH_DIV        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] bcd_i,
  input  logic              latch_en_i,
  input  logic              blank_i,
  input  logic              phase_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic              backplane_o
);
  logic              srst_n;
  logic [CODE_W-1:0] code_q, code_eff;
  logic              phase_sel;
  logic              dark;
  logic [SEG_W-1:0]  seg_nxt, seg_q;
  logic              bp_q;

  lcd7_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  lcd7_code_store #(.W(CODE_W)) u_store (
    .clk      (clk),
    .srst_n   (srst_n),
    .load_en  (latch_en_i),
    .code_in  (bcd_i),
    .code_q   (code_q),
    .code_eff (code_eff)
  );

  if (USE_PHASE_GEN) begin : g_ph_int
    lcd7_phase_gen #(.DIV(PH_DIV)) u_ph (
      .clk    (clk),
      .srst_n (srst_n),
      .phase  (phase_sel)
    );
  end else begin : g_ph_ext
    assign phase_sel = phase_i;
  end

  assign dark = blank_i | ~srst_n;

  lcd7_seg_decode #(.W(CODE_W), .S(SEG_W)) u_dec (
    .code  (code_eff),
    .dark  (dark),
    .phase (phase_sel),
    .seg   (seg_nxt)
  );

  // Output stage: loaded every cycle, during reset it carries the blank word.
  always_ff @(posedge clk) begin
    seg_q <= seg_nxt;
    bp_q  <= phase_sel;
  end

  assign seg_o       = seg_q;
  assign backplane_o = bp_q;

  assert_blank_word_R5: assert property (@(posedge clk) disable iff (!srst_n)
    blank_i |=> (seg_o == {SEG_W{$past(phase_sel)}}));

  assert_invalid_dark_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (code_eff > CODE_W'(N_DIGITS - 1)) |=> (seg_o == {SEG_W{$past(phase_sel)}}));

  assert_backplane_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (backplane_o == $past(phase_sel)));

  assert_reset_blank_R7: assert property (@(posedge clk)
    (!srst_n && !$isunknown(phase_sel)) |=> (seg_o == {SEG_W{$past(phase_sel)}}));
endmodule

// File: tb/lcd7_driver_test.sv
module lcd7_driver_test;
  localparam int CLK_PERIOD = 10;
  localparam int GEN_DIV    = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bcd;
  logic       le, bl, ph;
  logic [6:0] seg, seg_g;
  logic       bp, bp_g;

  int checks = 0;
  int bad    = 0;
  logic [3:0] mcode;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd7_driver #(.USE_PHASE_GEN(1'b0), .PH_DIV(8)) uut (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd), .latch_en_i(le),
    .blank_i(bl), .phase_i(ph), .seg_o(seg), .backplane_o(bp)
  );

  lcd7_driver #(.USE_PHASE_GEN(1'b1), .PH_DIV(GEN_DIV)) uut_gen (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd), .latch_en_i(le),
    .blank_i(bl), .phase_i(ph), .seg_o(seg_g), .backplane_o(bp_g)
  );

  function automatic logic [6:0] digit_word(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expect_word(input logic [3:0] c, input logic b,
                                             input logic p);
    return (b ? 7'h00 : digit_word(c)) ^ {7{p}};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge.
  task automatic step(input logic [3:0] d, input logic l, input logic b,
                      input logic p, input string req);
    logic [3:0] eff;
    @(negedge clk);
    bcd = d; le = l; bl = b; ph = p;
    @(posedge clk);
    #1;
    if (l) mcode = d;
    eff = mcode;
    check(req, {1'b0, seg}, {1'b0, expect_word(eff, b, p)});
    check("R8", {7'b0, bp}, {7'b0, p});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int seed;
    int last_bp, run, toggles, seen;
    seed = $urandom(32'h5EC7);
    rst_n = 1'b0; bcd = 4'd5; le = 1'b1; bl = 1'b0; ph = 1'b1;
    mcode = 4'd0;

    // R7: blank word during reset, for both phases.
    @(negedge clk); @(posedge clk); #1;
    check("R7", {1'b0, seg}, 8'h7F);
    @(negedge clk); ph = 1'b0;
    @(posedge clk); #1;
    check("R7", {1'b0, seg}, 8'h00);
    check("R8", {7'b0, bp}, 8'h00);

    // Release with the enable low, wait out the synchronizer.
    @(negedge clk); rst_n = 1'b1; le = 1'b0; bcd = 4'd9;
    repeat (3) @(posedge clk);
    #1;
    mcode = 4'd0;
    step(4'd9, 1'b0, 1'b0, 1'b0, "R7");

    // R1 / R4: every code in both phases, transparent store.
    for (int c = 0; c < 16; c++) begin
      step(4'(c), 1'b1, 1'b0, 1'b0, (c > 9) ? "R4" : "R1");
      step(4'(c), 1'b1, 1'b0, 1'b1, "R6");
    end

    // R2: one-cycle follow.
    step(4'd3, 1'b1, 1'b0, 1'b0, "R2");
    step(4'd8, 1'b1, 1'b0, 1'b0, "R2");

    // R3: enable low, data changes ignored.
    step(4'd1, 1'b0, 1'b0, 1'b0, "R3");
    step(4'd7, 1'b0, 1'b0, 1'b1, "R3");
    step(4'd12, 1'b0, 1'b0, 1'b0, "R3");

    // R5: blank over a held code, then the held code returns.
    step(4'd2, 1'b0, 1'b1, 1'b0, "R5");
    step(4'd2, 1'b0, 1'b1, 1'b1, "R6");
    step(4'd2, 1'b0, 1'b0, 1'b0, "R5");

    // Constrained random mix.
    for (int i = 0; i < 400; i++) begin
      logic [3:0] d;
      d = ($urandom % 4 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      step(d, 1'($urandom % 3 != 0), 1'($urandom % 5 == 0), 1'($urandom % 2),
           "R2");
    end

    // R9: internal phase generator, pin phase random.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; le = 1'b1; bcd = 4'd1; bl = 1'b0;
    repeat (3) @(posedge clk);
    last_bp = -1; run = 0; toggles = 0; seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); ph = 1'($urandom % 2);
      @(posedge clk); #1;
      check("R9", {1'b0, seg_g}, {1'b0, 7'h06 ^ {7{bp_g}}});
      if (last_bp >= 0 && int'(bp_g) != last_bp) begin
        toggles++;
        if (seen != 0) check("R9", 8'(run), 8'(GEN_DIV / 2));
        seen = 1;
        run = 1;
      end else begin
        run++;
      end
      last_bp = int'(bp_g);
    end
    check("R9", {7'b0, toggles >= 15}, 8'h01);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule